// File: doc/BRIEF.md
# Arithmetic Logic Unit with Flags

This block performs one integer operation at a time on two operands, using either the low byte or the full 16-bit word. It keeps a 16-bit flags word up to date. Six status bits describe each arithmetic or logic result: carry, parity, auxiliary carry, zero, sign and overflow. Three control bits (trap, interrupt, direction) live beside them. Carry, direction and interrupt can also be forced to 1 or 0 by operations that do no arithmetic at all.

A small controller has two named states. In `ST_IDLE` the block waits. When `op_valid` is high at a rising edge, the opcode, size select and operands are captured, and the transition `IDLE->EXEC` is taken. In `ST_EXEC` the captured operation is evaluated and committed to `result` and `flags`, and the transition `EXEC->IDLE` is always taken on the next edge. The `busy` output is high while the controller is in `ST_EXEC`. The `done` output pulses for the one cycle that follows the commit.

Top module: `alu_flags_unit`

## Requirements
- R1: When `op_valid` is high at edge k while the block is idle, `busy` is high after edge k. After edge k+1, `done` is high for exactly one cycle, and `result`/`flags` hold the new values.
- R2: `op_valid` is ignored while `busy` is high, and `busy` never stays high for two consecutive cycles.
- R3: ADD (code 0) and ADC (code 1) compute a+b and a+b+CF. CF is the carry out of the top bit of the selected size, AF is the carry out of bit 3, and OF is set when the two operands have the same sign and the result sign differs.
- R4: SUB (code 2) and SBB (code 3) compute a-b and a-b-CF. CF is the borrow out of the top bit, AF is the borrow out of bit 3, and OF is set when the operands have different signs and the result sign differs from a.
- R5: AND (code 4), OR (code 5) and XOR (code 6) clear CF and OF and leave AF as it was.
- R6: After any of codes 0-6, PF (bit 2) is 1 when bits 7..0 of the result hold an even number of ones, and 0 otherwise. Upper bits are not counted.
- R7: After any of codes 0-6, ZF (bit 6) is 1 exactly when the result is zero in the selected size, and SF (bit 7) copies the top bit of that size.
- R8: With `byte_mode` high, only operand bits 7..0 are used. Result bits 15..8 are 0, and CF, OF, SF and ZF refer to the 8-bit value.
- R9: Codes 7/8 set/clear CF (bit 0), codes 9/10 set/clear DF (bit 10), and codes 11/12 set/clear IF (bit 9). Each changes only that bit and leaves `result` unchanged.
- R10: After reset `flags`, `result`, `busy` and `done` are 0. TF (bit 8) and bits 1, 3, 5, 12-15 always read 0. The status bits are CF=0, PF=2, AF=4, ZF=6, SF=7 and OF=11.
- R11: Codes 13-15 change neither `result` nor `flags`, and still produce the `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Start an operation (sampled while idle) |
| op_code | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opnd_a | input | 16 | First operand (minuend for subtraction) |
| opnd_b | input | 16 | Second operand |
| busy | output | 1 | Controller is in the execute state |
| done | output | 1 | One-cycle pulse after commit |
| result | output | 16 | Last arithmetic/logic result |
| flags | output | 16 | Flags word |

## Verification
An operation accepted at edge k shows `busy` after edge k. Its `result`, `flags` and `done` appear only after edge k+1, and `done` falls after edge k+2. Every scenario task drives its inputs at a falling edge and samples at the following falling edges. In those tasks the busy check sits one half-cycle after acceptance, and the result, flag and done checks sit one full cycle after it. A last check one cycle later confirms that `done` has fallen. The reference flags are carried across operations in the bench, so ADC, SBB and the AF-retention cases see the same incoming flags that the design saw.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int FLAG_W = 16;
    localparam int NIB_W  = 4;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;

    localparam logic [FLAG_W-1:0] FLAG_USED = 16'h0FD5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SETC = 4'd7,
        OP_CLRC = 4'd8,
        OP_SETD = 4'd9,
        OP_CLRD = 4'd10,
        OP_SETI = 4'd11,
        OP_CLRI = 4'd12
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } st_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         subtract,
    input  logic         byte_mode,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         aux,
    output logic         ovf
);
    import alu_flags_pkg::*;

    localparam int H = W / 2;

    logic [W-1:0]     b_eff;
    logic             c0;
    logic [W:0]       sum_w;
    logic [H:0]       sum_h;
    logic [NIB_W:0]   sum_n;
    logic             a_top, b_top, r_top, raw_carry;

    always_comb begin
        b_eff = subtract ? ~b : b;
        c0    = subtract ? ~cin : cin;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum_h = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
        sum_n = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c0};
        if (byte_mode) begin
            res       = {{(W-H){1'b0}}, sum_h[H-1:0]};
            raw_carry = sum_h[H];
            a_top     = a[H-1];
            b_top     = b_eff[H-1];
            r_top     = sum_h[H-1];
        end else begin
            res       = sum_w[W-1:0];
            raw_carry = sum_w[W];
            a_top     = a[W-1];
            b_top     = b_eff[W-1];
            r_top     = sum_w[W-1];
        end
        cout = raw_carry ^ subtract;
        aux  = sum_n[NIB_W] ^ subtract;
        ovf  = (a_top == b_top) && (r_top != a_top);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    input  logic         byte_mode,
    output logic [W-1:0] res
);
    localparam int H = W / 2;

    logic [W-1:0] raw;

    always_comb begin
        unique case (sel)
            2'b00:   raw = a & b;
            2'b01:   raw = a | b;
            default: raw = a ^ b;
        endcase
        res = byte_mode ? {{(W-H){1'b0}}, raw[H-1:0]} : raw;
    end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         byte_mode,
    output logic         parity_even,
    output logic         is_zero,
    output logic         sign
);
    localparam int H = W / 2;

    generate
        if (H >= 8) begin : g_par_byte
            assign parity_even = ~^val[7:0];
        end else begin : g_par_half
            assign parity_even = ~^val[H-1:0];
        end
    endgenerate

    always_comb begin
        if (byte_mode) begin
            is_zero = (val[H-1:0] == '0);
            sign    = val[H-1];
        end else begin
            is_zero = (val == '0);
            sign    = val[W-1];
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic         byte_mode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [15:0]  flags
);
    import alu_flags_pkg::*;

    st_e          state, state_nxt;
    op_e          op_q;
    logic         bm_q;
    logic [W-1:0] a_q, b_q;

    logic [W-1:0] as_res, lg_res, stat_in, nxt_result;
    logic         as_cout, as_aux, as_ovf;
    logic         is_arith, is_logic, is_sub, use_cin;
    logic         st_par, st_zero, st_sign;
    logic [15:0]  nxt_flags;

    // controller: next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (op_valid) state_nxt = ST_EXEC;
            ST_EXEC: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // operand capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
            bm_q <= 1'b0;
            a_q  <= '0;
            b_q  <= '0;
        end else if (state == ST_IDLE && op_valid) begin
            op_q <= op_e'(op_code);
            bm_q <= byte_mode;
            a_q  <= opnd_a;
            b_q  <= opnd_b;
        end
    end

    always_comb begin
        is_arith = (op_q == OP_ADD) || (op_q == OP_ADC) ||
                   (op_q == OP_SUB) || (op_q == OP_SBB);
        is_logic = (op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR);
        is_sub   = (op_q == OP_SUB) || (op_q == OP_SBB);
        use_cin  = ((op_q == OP_ADC) || (op_q == OP_SBB)) && flags[CF_BIT];
        stat_in  = is_arith ? as_res : lg_res;
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(a_q), .b(b_q), .cin(use_cin), .subtract(is_sub), .byte_mode(bm_q),
        .res(as_res), .cout(as_cout), .aux(as_aux), .ovf(as_ovf)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a(a_q), .b(b_q), .sel(op_q[1:0] - 2'd0), .byte_mode(bm_q), .res(lg_res)
    );

    alu_status #(.W(W)) u_status (
        .val(stat_in), .byte_mode(bm_q),
        .parity_even(st_par), .is_zero(st_zero), .sign(st_sign)
    );

    // next result and flags for the captured operation
    always_comb begin
        nxt_flags  = flags;
        nxt_result = result;
        unique case (op_q)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                nxt_result        = as_res;
                nxt_flags[CF_BIT] = as_cout;
                nxt_flags[AF_BIT] = as_aux;
                nxt_flags[OF_BIT] = as_ovf;
                nxt_flags[PF_BIT] = st_par;
                nxt_flags[ZF_BIT] = st_zero;
                nxt_flags[SF_BIT] = st_sign;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_result        = lg_res;
                nxt_flags[CF_BIT] = 1'b0;
                nxt_flags[OF_BIT] = 1'b0;
                nxt_flags[PF_BIT] = st_par;
                nxt_flags[ZF_BIT] = st_zero;
                nxt_flags[SF_BIT] = st_sign;
            end
            OP_SETC: nxt_flags[CF_BIT] = 1'b1;
            OP_CLRC: nxt_flags[CF_BIT] = 1'b0;
            OP_SETD: nxt_flags[DF_BIT] = 1'b1;
            OP_CLRD: nxt_flags[DF_BIT] = 1'b0;
            OP_SETI: nxt_flags[IF_BIT] = 1'b1;
            OP_CLRI: nxt_flags[IF_BIT] = 1'b0;
            default: ;
        endcase
        nxt_flags = nxt_flags & FLAG_USED;
        nxt_flags[TF_BIT] = 1'b0;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            flags  <= '0;
            done   <= 1'b0;
        end else begin
            done <= (state == ST_EXEC);
            if (state == ST_EXEC) begin
                result <= nxt_result;
                flags  <= nxt_flags;
            end
        end
    end

    assign busy = (state == ST_EXEC);

endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [15:0]  flags,
    input logic [3:0]   cur_op,
    input logic         cur_byte
);
    localparam int H = W / 2;

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~16'h0FD5) == 16'h0000);

    assert_trap_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flags[8] == 1'b0);

    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op >= 4'd4 && cur_op <= 4'd6) |-> (!flags[0] && !flags[11]));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op <= 4'd6 && !cur_byte) |-> (flags[6] == (result == '0)));

    assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op <= 4'd6 && cur_byte) |-> (result[W-1:H] == '0));

    assert_ctl_keeps_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op >= 4'd7) |-> $stable(result));

endmodule

bind alu_flags_unit alu_flags_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .result(result), .flags(flags), .cur_op(op_q), .cur_byte(bm_q)
);

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = 16'd0, opnd_b = 16'd0;
    logic        busy, done;
    logic [15:0] result, flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] mres = 16'd0;
    logic [15:0] mflags = 16'd0;

    always #2 clk = ~clk;

    alu_flags_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .result(result), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic predict(input logic [3:0] op, input logic bm, input logic [15:0] a, input logic [15:0] b);
        int sz = bm ? 8 : 16;
        int mask = bm ? 'hFF : 'hFFFF;
        int aa = int'(a) & mask;
        int bb = int'(b) & mask;
        int c = 0;
        int r = 0;
        bit sa, sb, sr;
        sa = aa[sz-1];
        sb = bb[sz-1];
        case (op)
            4'd0, 4'd1: begin
                c = (op == 4'd1) ? int'(mflags[0]) : 0;
                r = aa + bb + c;
                mflags[0] = r[sz];
                mflags[4] = ((aa & 15) + (bb & 15) + c) > 15;
                r = r & mask;
                sr = r[sz-1];
                mflags[11] = (sa == sb) && (sr != sa);
            end
            4'd2, 4'd3: begin
                c = (op == 4'd3) ? int'(mflags[0]) : 0;
                mflags[0] = aa < (bb + c);
                mflags[4] = (aa & 15) < ((bb & 15) + c);
                r = (aa - bb - c) & mask;
                sr = r[sz-1];
                mflags[11] = (sa != sb) && (sr != sa);
            end
            4'd4: r = aa & bb;
            4'd5: r = aa | bb;
            4'd6: r = aa ^ bb;
            4'd7:  mflags[0] = 1'b1;
            4'd8:  mflags[0] = 1'b0;
            4'd9:  mflags[10] = 1'b1;
            4'd10: mflags[10] = 1'b0;
            4'd11: mflags[9] = 1'b1;
            4'd12: mflags[9] = 1'b0;
            default: ;
        endcase
        if (op >= 4'd4 && op <= 4'd6) begin
            mflags[0] = 1'b0;
            mflags[11] = 1'b0;
        end
        if (op <= 4'd6) begin
            mres = r[15:0];
            mflags[2] = ~^r[7:0];
            mflags[6] = (r == 0);
            mflags[7] = r[sz-1];
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic bm, input logic [15:0] a,
                         input logic [15:0] b, input string tag);
        predict(op, bm, a, b);
        op_code = op; byte_mode = bm; opnd_a = a; opnd_b = b; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy === 1'b1, {tag, " R1 busy after accept"}, {15'd0, busy}, 16'd1);
        chk(done === 1'b0, {tag, " R1 done not early"}, {15'd0, done}, 16'd0);
        @(negedge clk);
        chk(done === 1'b1, {tag, " R1 done pulse"}, {15'd0, done}, 16'd1);
        chk(result === mres, {tag, " result"}, result, mres);
        chk(flags === mflags, {tag, " flags"}, flags, mflags);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R1 done one cycle"}, {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset;
        chk(flags === 16'h0000, "R10 reset flags", flags, 16'h0000);
        chk(result === 16'h0000, "R10 reset result", result, 16'h0000);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset busy/done", {14'd0, busy, done}, 16'd0);
    endtask

    task automatic t_add;
        do_op(4'd0, 1'b0, 16'h7FFF, 16'h0001, "R3 add signed overflow");
        chk(flags === 16'h0894, "R3 R7 add 7FFF+1 flag word", flags, 16'h0894);
        do_op(4'd0, 1'b0, 16'hFFFF, 16'h0001, "R3 add carry out");
        chk(flags === 16'h0055, "R3 R7 add FFFF+1 flag word", flags, 16'h0055);
        do_op(4'd1, 1'b0, 16'h0001, 16'h0001, "R3 adc with CF=1");
        chk(result === 16'h0003, "R3 adc result", result, 16'h0003);
        do_op(4'd0, 1'b0, 16'h1234, 16'h4321, "R3 add plain");
    endtask

    task automatic t_sub;
        do_op(4'd2, 1'b0, 16'h0000, 16'h0001, "R4 sub borrow");
        chk(flags === 16'h0095, "R4 sub 0-1 flag word", flags, 16'h0095);
        do_op(4'd3, 1'b0, 16'h0005, 16'h0003, "R4 sbb with CF=1");
        chk(result === 16'h0001, "R4 sbb result", result, 16'h0001);
        do_op(4'd2, 1'b0, 16'h8000, 16'h0001, "R4 sub signed overflow");
        do_op(4'd3, 1'b0, 16'h0010, 16'h0001, "R4 sbb nibble borrow");
    endtask

    task automatic t_logic;
        do_op(4'd0, 1'b0, 16'h000F, 16'h0001, "R3 set AF before logic");
        do_op(4'd4, 1'b0, 16'hF0F0, 16'h0FF0, "R5 and keeps AF");
        chk(flags[4] === 1'b1, "R5 AF retained", {15'd0, flags[4]}, 16'd1);
        do_op(4'd5, 1'b0, 16'h8001, 16'h0100, "R5 or");
        do_op(4'd6, 1'b0, 16'h1234, 16'h1234, "R5 R7 xor zero");
        chk(flags[6] === 1'b1, "R7 ZF after xor", {15'd0, flags[6]}, 16'd1);
    endtask

    task automatic t_parity;
        do_op(4'd0, 1'b0, 16'h0100, 16'h0000, "R6 parity low byte only");
        chk(flags[2] === 1'b1, "R6 PF even for 0100", {15'd0, flags[2]}, 16'd1);
        do_op(4'd0, 1'b0, 16'h0001, 16'h0000, "R6 parity odd");
        chk(flags[2] === 1'b0, "R6 PF odd for 0001", {15'd0, flags[2]}, 16'd0);
    endtask

    task automatic t_byte;
        do_op(4'd0, 1'b1, 16'h12FF, 16'h3401, "R8 byte add carry");
        chk(result === 16'h0000 && flags[0] === 1'b1, "R8 byte carry/zero", result, 16'h0000);
        do_op(4'd0, 1'b1, 16'hAA7F, 16'h5501, "R8 byte overflow");
        chk(result === 16'h0080, "R8 byte upper bits zero", result, 16'h0080);
        do_op(4'd2, 1'b1, 16'h0010, 16'h0020, "R8 byte sub borrow");
        do_op(4'd6, 1'b1, 16'hFF0F, 16'h00F0, "R8 byte xor sign");
    endtask

    task automatic t_ctl;
        do_op(4'd7,  1'b0, 16'hDEAD, 16'hBEEF, "R9 set CF");
        do_op(4'd9,  1'b0, 16'h0000, 16'h0000, "R9 set DF");
        do_op(4'd11, 1'b0, 16'h0000, 16'h0000, "R9 set IF");
        chk(flags[10:9] === 2'b11, "R9 DF IF set", {14'd0, flags[10:9]}, 16'd3);
        do_op(4'd8,  1'b0, 16'h0000, 16'h0000, "R9 clear CF");
        do_op(4'd10, 1'b0, 16'h0000, 16'h0000, "R9 clear DF");
        do_op(4'd12, 1'b0, 16'h0000, 16'h0000, "R9 clear IF");
    endtask

    task automatic t_busy_ignore;
        predict(4'd2, 1'b0, 16'h0003, 16'h0001);
        op_code = 4'd2; byte_mode = 1'b0; opnd_a = 16'h0003; opnd_b = 16'h0001; op_valid = 1'b1;
        @(negedge clk);
        op_code = 4'd7; opnd_a = 16'h0000;   // set-carry offered while busy
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy === 1'b0, "R2 no second accept", {15'd0, busy}, 16'd0);
        chk(flags === mflags, "R2 flags unaffected while busy", flags, mflags);
        @(negedge clk);
        chk(done === 1'b0 && flags === mflags, "R2 no extra commit", flags, mflags);
    endtask

    task automatic t_undef;
        do_op(4'd13, 1'b0, 16'hFFFF, 16'hFFFF, "R11 code 13 no effect");
        do_op(4'd15, 1'b1, 16'h0000, 16'h0001, "R11 code 15 no effect");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add();
        t_sub();
        t_logic();
        t_parity();
        t_byte();
        t_ctl();
        t_busy_ignore();
        t_undef();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule